// File: doc/BRIEF.md
# Instruction Subset Violation Checker

This block watches an instruction fetch port and reports every fetched word that steps outside the permitted instruction subset. Each cycle that `fetch_valid` is high it evaluates the 32-bit word `fetch_insn` together with the fetch stage's claim `fetch_is_comp` that the word is a compressed instruction. It raises one-cycle pulses for three causes:
- the claim disagrees with the encoding;
- an uncompressed instruction names a register at or beyond the permitted register count;
- the word matches an entry in a compile-time table of outlawed encodings.

A sticky error flag gathers every cause until reset.

Each table entry holds a pattern, a mask, a width and optional equality qualifiers on register fields. A 32-bit entry only looks at uncompressed words and compares bits 31..0. A 16-bit entry only looks at compressed words and compares bits 15..0. When a base instruction is outlawed and compressed instructions are in use, the table carries its compressed twin as a separate entry. The block takes no action on the core. It is meant to sit beside a fetch stage as a monitor, or to feed an interrupt or trace unit.

Top module: `isa_subset_guard`

## Requirements
- R1: With `fetch_valid` high, table entry i fires when (word AND mask) equals its pattern, its width agrees with the encoding and its qualifiers hold. `viol_rule_hit[i]` and `viol_rule_any` then pulse.
- R2: A word counts as compressed exactly when bits[1:0] are not 2'b11. `viol_encoding` pulses when `fetch_is_comp` disagrees with that.
- R3: A 32-bit entry never fires on a compressed word. A 16-bit entry never fires on an uncompressed word, and it ignores bits[31:16].
- R4: With `REG_COUNT` = 16, an uncompressed word whose format uses a register field holding a value of 16 or more pulses `viol_regrange`. The fields are rd = bits[11:7], rs1 = bits[19:15] and rs2 = bits[24:20]. The fields used by each major opcode are:
  - 0x33 and 0x3B: rd, rs1 and rs2.
  - 0x13, 0x03, 0x67 and 0x1B: rd and rs1.
  - 0x23 and 0x63: rs1 and rs2.
  - 0x37, 0x17 and 0x6F: rd only.
  - All other opcodes, and all compressed words: no field is checked.
- R5: The default entry 3 (pattern 0x00000033, mask 0xFE00707F, 32-bit) carries the qualifier rd = x0. It fires only when bits[11:7] are zero.
- R6: The default table outlaws both a base instruction and its compressed twin. It also outlaws two multiplies and a divide. The entries are:
  - entry 0: pattern 0x02000033, mask 0xFE00707F.
  - entry 1: pattern 0x02001033, same mask.
  - entry 2: pattern 0x02004033, same mask.
  - entry 4: the base instruction, pattern 0x40000033, mask 0xFE00707F.
  - entry 5: its compressed twin, 16-bit, pattern 0x8C01, mask 0xFC63.
- R7: Every violation output is high exactly in the cycle after the fetch cycle that caused it, and low again afterwards unless a new violation follows.
- R8: `err_sticky` goes high together with the first violation pulse. It stays high until a synchronous reset.
- R9: While `fetch_valid` is low, no cause is evaluated. The next cycle shows no pulse and `err_sticky` does not change.
- R10: During and right after a synchronous reset (`rst_n` low), every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | Fetch word is valid this cycle |
| fetch_insn | input | 32 | Fetched instruction word |
| fetch_is_comp | input | 1 | Fetch stage's claim that the word is compressed |
| viol_encoding | output | 1 | Compressed claim disagrees with bits[1:0] |
| viol_regrange | output | 1 | Used register field beyond the permitted count |
| viol_rule_hit | output | NUM_RULES | Per-entry outlaw hit |
| viol_rule_any | output | 1 | Any table entry hit |
| err_sticky | output | 1 | Sticky OR of all violations |

## Verification
All causes are computed combinationally from the fetch inputs and captured by a single register stage. So every pulse and the sticky flag's update are due exactly one clock edge after the fetch cycle, and they are gone one edge later. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs against expectations that it computed when it drove those inputs. Each compare therefore lines up with the one register stage, and idle cycles are checked just as strictly as active ones.

// File: rtl/isg_pkg.sv
package isg_pkg;

  typedef struct packed {
    logic        en;
    logic        half;
    logic [31:0] pat;
    logic [31:0] msk;
    logic        rd_q;
    logic [4:0]  rd_v;
    logic        rs1_q;
    logic [4:0]  rs1_v;
    logic        rs2_q;
    logic [4:0]  rs2_v;
  } isg_rule_t;

  localparam logic [31:0] RTYPE_MASK = 32'hFE00707F;

  function automatic isg_rule_t mk_rule(input logic half, input logic [31:0] pat,
                                        input logic [31:0] msk, input logic rd_q,
                                        input logic [4:0] rd_v);
    isg_rule_t r;
    r       = '0;
    r.en    = 1'b1;
    r.half  = half;
    r.pat   = pat;
    r.msk   = msk;
    r.rd_q  = rd_q;
    r.rd_v  = rd_v;
    return r;
  endfunction

  // Default outlaw table; indices beyond it are disabled slots.
  function automatic isg_rule_t default_rule(input int idx);
    case (idx)
      0:       return mk_rule(1'b0, 32'h02000033, RTYPE_MASK, 1'b0, 5'd0);
      1:       return mk_rule(1'b0, 32'h02001033, RTYPE_MASK, 1'b0, 5'd0);
      2:       return mk_rule(1'b0, 32'h02004033, RTYPE_MASK, 1'b0, 5'd0);
      3:       return mk_rule(1'b0, 32'h00000033, RTYPE_MASK, 1'b1, 5'd0);
      4:       return mk_rule(1'b0, 32'h40000033, RTYPE_MASK, 1'b0, 5'd0);
      5:       return mk_rule(1'b1, 32'h00008C01, 32'h0000FC63, 1'b0, 5'd0);
      default: return '0;
    endcase
  endfunction

  function automatic logic enc_is_compressed(input logic [31:0] w);
    return w[1:0] != 2'b11;
  endfunction

  // {uses_rd, uses_rs1, uses_rs2} for an uncompressed major opcode
  function automatic logic [2:0] used_fields(input logic [6:0] opc);
    if (opc[1:0] != 2'b11) return 3'b000;
    case (opc[6:2])
      5'b01100, 5'b01110:                   return 3'b111;
      5'b00100, 5'b00000, 5'b11001, 5'b00110: return 3'b110;
      5'b01000, 5'b11000:                   return 3'b011;
      5'b01101, 5'b00101, 5'b11011:         return 3'b100;
      default:                              return 3'b000;
    endcase
  endfunction

  function automatic logic reg_beyond(input logic [4:0] f, input int unsigned cnt);
    return 32'(f) >= cnt;
  endfunction

  function automatic logic rule_shape_ok(input isg_rule_t r, input logic [31:0] w);
    if (r.half) return (w[15:0] & r.msk[15:0]) == r.pat[15:0];
    return (w & r.msk) == r.pat;
  endfunction

  // Qualifier fields: 32-bit rd[11:7] rs1[19:15] rs2[24:20]; 16-bit rd/rs1[11:7] rs2[6:2]
  function automatic logic rule_qual_ok(input isg_rule_t r, input logic [31:0] w);
    logic [4:0] q_rd, q_rs1, q_rs2;
    q_rd  = w[11:7];
    q_rs1 = r.half ? w[11:7] : w[19:15];
    q_rs2 = r.half ? w[6:2]  : w[24:20];
    return (!r.rd_q  || (q_rd  == r.rd_v)) &&
           (!r.rs1_q || (q_rs1 == r.rs1_v)) &&
           (!r.rs2_q || (q_rs2 == r.rs2_v));
  endfunction

endpackage

// File: rtl/isg_decode.sv
module isg_decode
  import isg_pkg::*;
#(
  parameter int unsigned REG_COUNT = 16
) (
  input  logic [31:0] insn,
  input  logic        comp_flag,
  output logic        enc_comp,
  output logic        enc_mismatch,
  output logic        range_hit
);
  logic [4:0] f_rd, f_rs1, f_rs2;
  logic [2:0] uses;

  always_comb begin
    enc_comp     = enc_is_compressed(insn);
    enc_mismatch = comp_flag != enc_comp;
    f_rd         = insn[11:7];
    f_rs1        = insn[19:15];
    f_rs2        = insn[24:20];
    uses         = used_fields(insn[6:0]);
    range_hit    = !enc_comp &&
                   ((uses[2] && reg_beyond(f_rd,  REG_COUNT)) ||
                    (uses[1] && reg_beyond(f_rs1, REG_COUNT)) ||
                    (uses[0] && reg_beyond(f_rs2, REG_COUNT)));
  end
endmodule

// File: rtl/isg_rule_slot.sv
module isg_rule_slot
  import isg_pkg::*;
#(
  parameter isg_rule_t RULE = '0
) (
  input  logic [31:0] insn,
  input  logic        enc_comp,
  output logic        hit
);
  logic width_ok, shape_ok, qual_ok;

  always_comb begin
    width_ok = RULE.en && (RULE.half == enc_comp);
    shape_ok = rule_shape_ok(RULE, insn);
    qual_ok  = rule_qual_ok(RULE, insn);
    hit      = width_ok && shape_ok && qual_ok;
  end
endmodule

// File: rtl/isg_rule_bank.sv
module isg_rule_bank
  import isg_pkg::*;
#(
  parameter int NUM_RULES = 6
) (
  input  logic [31:0]          insn,
  input  logic                 enc_comp,
  output logic [NUM_RULES-1:0] hits
);
  for (genvar g = 0; g < NUM_RULES; g++) begin : g_slot
    isg_rule_slot #(.RULE(default_rule(g))) slot_i (
      .insn     (insn),
      .enc_comp (enc_comp),
      .hit      (hits[g])
    );
  end
endmodule

// File: rtl/isg_event_reg.sv
module isg_event_reg #(
  parameter int NUM_RULES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic                 enc_mismatch,
  input  logic                 range_hit,
  input  logic [NUM_RULES-1:0] hits,
  output logic                 q_enc,
  output logic                 q_range,
  output logic [NUM_RULES-1:0] q_hits,
  output logic                 q_any,
  output logic                 q_sticky
);
  logic now_any;

  always_comb now_any = valid && (enc_mismatch || range_hit || (|hits));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_enc    <= 1'b0;
      q_range  <= 1'b0;
      q_hits   <= '0;
      q_any    <= 1'b0;
      q_sticky <= 1'b0;
    end else begin
      q_enc    <= valid && enc_mismatch;
      q_range  <= valid && range_hit;
      q_hits   <= valid ? hits : '0;
      q_any    <= valid && (|hits);
      q_sticky <= q_sticky || now_any;
    end
  end
endmodule

// File: rtl/isa_subset_guard.sv
module isa_subset_guard
  import isg_pkg::*;
#(
  parameter int          NUM_RULES = 6,
  parameter int unsigned REG_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid,
  input  logic [31:0]          fetch_insn,
  input  logic                 fetch_is_comp,
  output logic                 viol_encoding,
  output logic                 viol_regrange,
  output logic [NUM_RULES-1:0] viol_rule_hit,
  output logic                 viol_rule_any,
  output logic                 err_sticky
);
  logic                 chk_enc_comp;
  logic                 chk_enc_mismatch;
  logic                 chk_range_hit;
  logic [NUM_RULES-1:0] chk_rule_hits;

  isg_decode #(.REG_COUNT(REG_COUNT)) dec_i (
    .insn         (fetch_insn),
    .comp_flag    (fetch_is_comp),
    .enc_comp     (chk_enc_comp),
    .enc_mismatch (chk_enc_mismatch),
    .range_hit    (chk_range_hit)
  );

  isg_rule_bank #(.NUM_RULES(NUM_RULES)) bank_i (
    .insn     (fetch_insn),
    .enc_comp (chk_enc_comp),
    .hits     (chk_rule_hits)
  );

  isg_event_reg #(.NUM_RULES(NUM_RULES)) evt_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (fetch_valid),
    .enc_mismatch (chk_enc_mismatch),
    .range_hit    (chk_range_hit),
    .hits         (chk_rule_hits),
    .q_enc        (viol_encoding),
    .q_range      (viol_regrange),
    .q_hits       (viol_rule_hit),
    .q_any        (viol_rule_any),
    .q_sticky     (err_sticky)
  );
endmodule

// File: rtl/isg_checker.sv
module isg_checker #(
  parameter int NUM_RULES = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetch_valid,
  input logic [31:0]          fetch_insn,
  input logic                 fetch_is_comp,
  input logic                 chk_enc_comp,
  input logic                 chk_range_hit,
  input logic [NUM_RULES-1:0] chk_rule_hits,
  input logic                 viol_encoding,
  input logic                 viol_regrange,
  input logic [NUM_RULES-1:0] viol_rule_hit,
  input logic                 viol_rule_any,
  input logic                 err_sticky
);
  // R2
  enc_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && (fetch_is_comp != (fetch_insn[1:0] != 2'b11)) |=> viol_encoding);

  // R2
  enc_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && (fetch_is_comp == (fetch_insn[1:0] != 2'b11)) |=> !viol_encoding);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !viol_encoding && !viol_regrange && !viol_rule_any && (viol_rule_hit == '0));

  // R4
  comp_no_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && (fetch_insn[1:0] != 2'b11) |=> !viol_regrange);

  // R3
  width_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_enc_comp |-> !chk_range_hit);

  // R1
  rule_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_rule_any == (viol_rule_hit != '0));

  // R1
  rule_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && (chk_rule_hits != '0) |=> viol_rule_any);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R8
  sticky_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_encoding || viol_regrange || viol_rule_any) |-> err_sticky);
endmodule

bind isa_subset_guard isg_checker #(.NUM_RULES(NUM_RULES)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_valid   (fetch_valid),
  .fetch_insn    (fetch_insn),
  .fetch_is_comp (fetch_is_comp),
  .chk_enc_comp  (chk_enc_comp),
  .chk_range_hit (chk_range_hit),
  .chk_rule_hits (chk_rule_hits),
  .viol_encoding (viol_encoding),
  .viol_regrange (viol_regrange),
  .viol_rule_hit (viol_rule_hit),
  .viol_rule_any (viol_rule_any),
  .err_sticky    (err_sticky)
);

// File: tb/isa_subset_guard_tb_top.sv
`timescale 1ns/1ps
module isa_subset_guard_tb_top;
  localparam int NR = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid;
  logic [31:0]   fetch_insn;
  logic          fetch_is_comp;
  logic          viol_encoding, viol_regrange, viol_rule_any, err_sticky;
  logic [NR-1:0] viol_rule_hit;

  always #2 clk = ~clk;

  isa_subset_guard #(.NUM_RULES(NR), .REG_COUNT(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_insn(fetch_insn),
    .fetch_is_comp(fetch_is_comp), .viol_encoding(viol_encoding),
    .viol_regrange(viol_regrange), .viol_rule_hit(viol_rule_hit),
    .viol_rule_any(viol_rule_any), .err_sticky(err_sticky)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] t_pat [NR];
  logic [31:0] t_msk [NR];
  bit          t_half[NR];
  bit          t_rdq [NR];

  bit have_exp, e_valid, e_enc, e_rr, e_any, e_sticky;
  logic [NR-1:0] e_vec;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // Register-range model (R4), written per full opcode value
  function automatic bit m_regs_bad(input logic [31:0] w);
    bit urd = 0, urs1 = 0, urs2 = 0;
    logic [6:0] op = w[6:0];
    if (w[1:0] != 2'b11) return 0;
    if (op == 7'h33 || op == 7'h3B) begin urd = 1; urs1 = 1; urs2 = 1; end
    else if (op == 7'h13 || op == 7'h03 || op == 7'h67 || op == 7'h1B) begin urd = 1; urs1 = 1; end
    else if (op == 7'h23 || op == 7'h63) begin urs1 = 1; urs2 = 1; end
    else if (op == 7'h37 || op == 7'h17 || op == 7'h6F) urd = 1;
    return (urd && w[11] == 1'b1) || (urs1 && w[19] == 1'b1) || (urs2 && w[24] == 1'b1);
  endfunction

  // Table-entry model (R1, R3, R5, R6)
  function automatic bit m_hit(input int k, input logic [31:0] w);
    bit comp = (w[1:0] != 2'b11);
    if (t_half[k] != comp) return 0;
    if (t_half[k]) begin
      if ((w[15:0] & t_msk[k][15:0]) != t_pat[k][15:0]) return 0;
    end else if ((w & t_msk[k]) != t_pat[k]) return 0;
    if (t_rdq[k] && w[11:7] != 5'd0) return 0;
    return 1;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h insn=%08h", tag, act, exp, fetch_insn);
    end
  endtask

  task automatic check_prev();
    string t;
    if (!have_exp) return;
    t = e_valid ? "R7" : "R9";
    cmp({t, "/R2 viol_encoding"}, 32'(viol_encoding), 32'(e_enc));
    cmp({t, "/R4 viol_regrange"}, 32'(viol_regrange), 32'(e_rr));
    cmp({t, "/R1/R3/R5/R6 viol_rule_hit"}, 32'(viol_rule_hit), 32'(e_vec));
    cmp({t, "/R1 viol_rule_any"}, 32'(viol_rule_any), 32'(e_any));
    cmp({t, "/R8 err_sticky"}, 32'(err_sticky), 32'(e_sticky));
  endtask

  task automatic step(input bit v, input logic [31:0] w, input bit c);
    @(negedge clk);
    check_prev();
    fetch_valid = v; fetch_insn = w; fetch_is_comp = c;
    e_valid = v;
    for (int k = 0; k < NR; k++) e_vec[k] = v && m_hit(k, w);
    e_enc = v && (c != (w[1:0] != 2'b11));
    e_rr  = v && m_regs_bad(w);
    e_any = (e_vec != '0);
    e_sticky = e_sticky || e_enc || e_rr || e_any;
    have_exp = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_prev();
    rst_n = 0; fetch_valid = 0; have_exp = 0;
    @(negedge clk);
    @(negedge clk);
    // R10 reset state; R8 sticky cleared only by reset
    cmp("R10 viol_encoding", 32'(viol_encoding), 0);
    cmp("R10 viol_regrange", 32'(viol_regrange), 0);
    cmp("R10 viol_rule_hit", 32'(viol_rule_hit), 0);
    cmp("R10 viol_rule_any", 32'(viol_rule_any), 0);
    cmp("R8/R10 err_sticky", 32'(err_sticky), 0);
    rst_n = 1;
    e_valid = 0; e_enc = 0; e_rr = 0; e_any = 0; e_vec = '0; e_sticky = 0;
    have_exp = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fetch_valid = 0; fetch_insn = '0; fetch_is_comp = 0;
    have_exp = 0; e_sticky = 0;
    t_pat[0] = 32'h02000033; t_msk[0] = 32'hFE00707F; t_half[0] = 0; t_rdq[0] = 0;
    t_pat[1] = 32'h02001033; t_msk[1] = 32'hFE00707F; t_half[1] = 0; t_rdq[1] = 0;
    t_pat[2] = 32'h02004033; t_msk[2] = 32'hFE00707F; t_half[2] = 0; t_rdq[2] = 0;
    t_pat[3] = 32'h00000033; t_msk[3] = 32'hFE00707F; t_half[3] = 0; t_rdq[3] = 1;
    t_pat[4] = 32'h40000033; t_msk[4] = 32'hFE00707F; t_half[4] = 0; t_rdq[4] = 0;
    t_pat[5] = 32'h00008C01; t_msk[5] = 32'h0000FC63; t_half[5] = 1; t_rdq[5] = 0;
    do_reset();

    // R9: idle word that would hit entry 0 and mismatch, valid low
    step(0, 32'h02000033, 1);
    // R5: rd=x0 qualified entry fires, rd=x1 does not
    step(1, 32'h00208033, 0);
    step(1, 32'h002080B3, 0);
    // R7: pulse clears on idle; R8 sticky holds
    step(0, 32'h0, 0);
    step(0, 32'h0, 0);
    do_reset();
    // R6: base and compressed twin both flagged
    step(1, 32'h402080B3, 0);
    step(1, 32'hFFFF8C05, 1);
    // R2: mismatching claim on an otherwise clean word
    step(1, 32'h00100093, 1);
    // R3: 16-bit pattern inside an uncompressed word, 32-bit pattern in a compressed word
    step(1, 32'h00008C03, 0);
    step(1, 32'h02000031, 1);
    do_reset();

    // R4: opcode sweep x field values across all three register fields
    for (int op = 0; op < 32; op++) begin
      for (int f = 0; f < 64; f++) begin
        logic [4:0] a, b, d;
        a = (f[1:0] == 0) ? 5'd0 : (f[1:0] == 1) ? 5'd15 : (f[1:0] == 2) ? 5'd16 : 5'd31;
        b = (f[3:2] == 0) ? 5'd0 : (f[3:2] == 1) ? 5'd15 : (f[3:2] == 2) ? 5'd16 : 5'd31;
        d = (f[5:4] == 0) ? 5'd0 : (f[5:4] == 1) ? 5'd15 : (f[5:4] == 2) ? 5'd16 : 5'd31;
        step(1, {7'h00, d, b, 3'b000, a, op[4:0], 2'b11}, 0);
      end
      do_reset();
    end

    // R3/R2: exhaustive low half-word sweep with random upper bits
    for (int i = 0; i < 65536; i++) begin
      lcg = nxt(lcg);
      step(1, {lcg[31:16], i[15:0]}, (i[1:0] != 2'b11) ^ (i[7:5] == 3'b101));
    end
    do_reset();

    // R1: random words, every fourth forced onto a table entry
    for (int i = 0; i < 20000; i++) begin
      logic [31:0] w;
      int k;
      lcg = nxt(lcg);
      w = lcg;
      k = int'(lcg[7:4]) % NR;
      if (lcg[3:2] == 2'b00) w = (nxt(lcg) & ~t_msk[k]) | t_pat[k];
      if (i % 512 == 511) do_reset();
      step(lcg[9] | lcg[10], w, (w[1:0] != 2'b11) ^ (lcg[15:11] == 0));
    end

    step(0, 32'h0, 0);
    @(negedge clk);
    check_prev();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule